// File: doc/BRIEF.md
# Byte-Merging SECDED Word Store

This block is the store and read path of a small data array in which every 32-bit word is kept as a 39-bit codeword. The codeword can correct one flipped bit and detect two. Stores arrive with a 4-bit byte-enable mask. A store that supplies all four bytes of a word is encoded and written with no read. A store that supplies only some bytes cannot form check bits alone. It therefore starts an atomic sequence: read the old codeword, correct it, merge the new bytes, re-encode and write back.

To avoid that sequence where possible, a one-entry merge buffer collects narrow stores to the same word. A word whose four bytes have all been written is committed like a full store. The buffer also commits when a store targets a different word or when a flush pulse arrives. While a read-modify-write is in flight the store port is stalled. Reads have one cycle of latency. They return the newest bytes, whether those bytes sit in the array, in the read-modify-write registers or in the merge buffer, together with correction and detection flags for the stored word. An error-injection mask is applied to every codeword write so that the correction paths can be exercised.

Top module: `ecc_rmw_store`

## Requirements
- R1: A codeword has 39 bits. Bit 0 is even parity over bits 38:1. Bits 1, 2, 4, 8, 16 and 32 are Hamming checks, where check bit 2^k covers every position 1..38 that has bit k set. The data bits fill the remaining positions in ascending order. After reset every word holds the all-zero codeword, and a read of a clean word returns its data with rd_corrected=0 and rd_uncorrectable=0.
- R2: A word with exactly one flipped codeword bit, bit 0 included, is read back with the original data and rd_corrected=1, rd_uncorrectable=0.
- R3: A word with exactly two flipped codeword bits is read back with rd_uncorrectable=1 and rd_corrected=0.
- R4: A buffered word whose mask covers all four bytes is committed the cycle after it becomes full, with no read of the array. This holds both for a store with st_be=4'b1111 and for narrow stores that together fill the word. st_ready stays 1 throughout.
- R5: Committing a word with a partial mask starts a read-modify-write. st_ready is 0 for exactly the two cycles after the commit edge. The word is rewritten as the merged value with fresh check bits, and a single-bit error in the old word is corrected and removed.
- R6: Stores to the word held in the merge buffer merge into it: st_be bit i carries st_data[8i+7:8i]. The buffer commits on a store to a different word, on a full mask, or on a flush pulse while no read-modify-write is running. Stores with st_be=0 are ignored.
- R7: rd_ack is 1 in the cycle after rd_en. rd_data shows the newest stored bytes, including bytes still in the merge buffer or in a running read-modify-write.
- R8: If the old word of a read-modify-write has a double error, the store is dropped, the word is left unchanged and rmw_abort is 1 for exactly one cycle.
- R9: inj_flip is XORed into the codeword of every array write in the cycle of that write.
- R10: During and right after reset, st_ready=1, rd_ack=0 and rmw_abort=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted when high; low during read-modify-write |
| st_addr | input | AW | Word address of the store |
| st_be | input | 4 | Byte enables of the store |
| st_data | input | 32 | Store data |
| flush | input | 1 | Commit the merge buffer |
| inj_flip | input | 39 | Codeword bits inverted on array writes |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Word address of the read |
| rd_ack | output | 1 | Read result valid |
| rd_data | output | 32 | Read data, corrected |
| rd_corrected | output | 1 | Stored word had a single-bit error |
| rd_uncorrectable | output | 1 | Stored word had a double-bit error |
| rmw_abort | output | 1 | Read-modify-write dropped due to a double error |

## Verification
The bench builds the block with its default depth of 16 words. Sixteen words leave room to keep the merge buffer, an in-flight read-modify-write and several deliberately corrupted words apart at different addresses. The injection mask places single flips in data, check and overall-parity positions, and a pair of flips drives a read-modify-write into its abort path. The stall pattern of st_ready shows whether a commit went direct or through the read-modify-write.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int DW    = 32;
    localparam int CW    = 39;
    localparam int NBYTE = DW / 8;
    localparam int NCHK  = 6;
    localparam int HTOP  = CW - 1;

    typedef enum logic [1:0] {S_IDLE, S_READ, S_MERGE} rmw_state_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          sgl;
        logic          dbl;
    } ecc_dec_t;

    function automatic logic [CW-1:0] ecc_encode(input logic [DW-1:0] d);
        logic [CW-1:0] cw;
        int k;
        cw = '0;
        k  = 0;
        for (int p = 1; p <= HTOP; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[6'(p)] = d[5'(k)];
                k++;
            end
        end
        for (int b = 0; b < NCHK; b++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p <= HTOP; p++)
                if (((p >> b) & 1) != 0) x = x ^ cw[6'(p)];
            cw[6'(1 << b)] = x;
        end
        cw[0] = ^cw[CW-1:1];
        return cw;
    endfunction

    function automatic ecc_dec_t ecc_decode(input logic [CW-1:0] cw);
        ecc_dec_t r;
        logic [5:0] syn;
        logic par;
        logic [CW-1:0] fx;
        int k;
        syn = '0;
        for (int p = 1; p <= HTOP; p++)
            if (cw[6'(p)]) syn = syn ^ 6'(p);
        par = ^cw;
        fx  = cw;
        r.sgl = 1'b0;
        r.dbl = 1'b0;
        if (par) begin
            if (syn > 6'(HTOP)) r.dbl = 1'b1;
            else begin
                r.sgl = 1'b1;
                if (syn != 0) fx[syn] = ~fx[syn];
            end
        end else if (syn != 0) begin
            r.dbl = 1'b1;
        end
        k = 0;
        r.data = '0;
        for (int p = 1; p <= HTOP; p++) begin
            if ((p & (p - 1)) != 0) begin
                r.data[5'(k)] = fx[6'(p)];
                k++;
            end
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] byte_overlay(input logic [DW-1:0] base,
                                                   input logic [DW-1:0] nw,
                                                   input logic [NBYTE-1:0] m);
        logic [DW-1:0] r;
        r = base;
        for (int i = 0; i < NBYTE; i++)
            if (m[i]) r[i*8 +: 8] = nw[i*8 +: 8];
        return r;
    endfunction

endpackage

// File: rtl/ecc_word_array.sv
module ecc_word_array
    import ecc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [CW-1:0] wcode,
    input  logic [AW-1:0] raddr_a,
    output logic [CW-1:0] rcode_a,
    input  logic [AW-1:0] raddr_b,
    output logic [CW-1:0] rcode_b
);
    logic [CW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wcode;
        end
    end

    assign rcode_a = mem[raddr_a];
    assign rcode_b = mem[raddr_b];

    // R9: a write lands in the addressed word on the next cycle
    p_write_lands_r9: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(waddr)] == $past(wcode));
endmodule

// File: rtl/ecc_merge_buf.sv
module ecc_merge_buf
    import ecc_pkg::*;
#(
    parameter int AW = 4
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             commit,
    input  logic [AW-1:0]    in_addr,
    input  logic [NBYTE-1:0] in_be,
    input  logic [DW-1:0]    in_data,
    output logic             bv,
    output logic [AW-1:0]    baddr,
    output logic [NBYTE-1:0] bmask,
    output logic [DW-1:0]    bdata,
    output logic             bfull
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bv    <= 1'b0;
            baddr <= '0;
            bmask <= '0;
            bdata <= '0;
        end else if (commit || (load && !bv)) begin
            bv <= load;
            if (load) begin
                baddr <= in_addr;
                bmask <= in_be;
                bdata <= in_data;
            end
        end else if (load) begin
            bmask <= bmask | in_be;
            bdata <= byte_overlay(bdata, in_data, in_be);
        end
    end

    assign bfull = bv && (bmask == {NBYTE{1'b1}});

    // R6: a held entry always owns at least one byte
    p_mask_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        bv |-> bmask != '0);
    // R6: a merge into a held entry keeps its address
    p_merge_same_word_r6: assert property (@(posedge clk) disable iff (rst)
        (load && bv && !commit) |=> (bv && baddr == $past(baddr)));
endmodule

// File: rtl/ecc_rmw_store.sv
module ecc_rmw_store
    import ecc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             st_valid,
    output logic             st_ready,
    input  logic [AW-1:0]    st_addr,
    input  logic [NBYTE-1:0] st_be,
    input  logic [DW-1:0]    st_data,
    input  logic             flush,
    input  logic [CW-1:0]    inj_flip,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic             rd_ack,
    output logic [DW-1:0]    rd_data,
    output logic             rd_corrected,
    output logic             rd_uncorrectable,
    output logic             rmw_abort
);
    rmw_state_e       state_q;
    logic             idle, st_fire, commit, commit_full, commit_part;
    logic             bv, bfull;
    logic [AW-1:0]    baddr;
    logic [NBYTE-1:0] bmask;
    logic [DW-1:0]    bdata;
    logic [AW-1:0]    r_addr;
    logic [NBYTE-1:0] r_mask;
    logic [DW-1:0]    r_data;
    logic [CW-1:0]    r_code, arr_code_a, arr_code_b, arr_wcode, enc_word;
    logic             arr_we;
    logic [AW-1:0]    arr_waddr;
    ecc_dec_t         mdec, rdec, wchk;
    logic [DW-1:0]    merged, rd_view;

    assign idle        = (state_q == S_IDLE);
    assign st_ready    = idle;
    assign st_fire     = st_valid && idle && (st_be != '0);
    assign commit      = idle && bv && (bfull || flush || (st_fire && st_addr != baddr));
    assign commit_full = commit && bfull;
    assign commit_part = commit && !bfull;

    ecc_merge_buf #(.AW(AW)) u_buf (
        .clk(clk), .rst(rst), .load(st_fire), .commit(commit),
        .in_addr(st_addr), .in_be(st_be), .in_data(st_data),
        .bv(bv), .baddr(baddr), .bmask(bmask), .bdata(bdata), .bfull(bfull)
    );

    ecc_word_array #(.DEPTH(DEPTH)) u_arr (
        .clk(clk), .rst(rst), .we(arr_we), .waddr(arr_waddr), .wcode(arr_wcode),
        .raddr_a(r_addr), .rcode_a(arr_code_a),
        .raddr_b(rd_addr), .rcode_b(arr_code_b)
    );

    // read-modify-write sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            r_addr    <= '0;
            r_mask    <= '0;
            r_data    <= '0;
            r_code    <= '0;
            rmw_abort <= 1'b0;
        end else begin
            rmw_abort <= (state_q == S_MERGE) && mdec.dbl;
            unique case (state_q)
                S_IDLE: if (commit_part) begin
                    state_q <= S_READ;
                    r_addr  <= baddr;
                    r_mask  <= bmask;
                    r_data  <= bdata;
                end
                S_READ: begin
                    r_code  <= arr_code_a;
                    state_q <= S_MERGE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mdec      = ecc_decode(r_code);
        merged    = byte_overlay(mdec.data, r_data, r_mask);
        enc_word  = ecc_encode(commit_full ? bdata : merged);
        arr_we    = commit_full || ((state_q == S_MERGE) && !mdec.dbl);
        arr_waddr = commit_full ? baddr : r_addr;
        arr_wcode = enc_word ^ inj_flip;
        wchk      = ecc_decode(enc_word);
    end

    // read port: stored word, then in-flight bytes, then buffered bytes
    always_comb begin
        rdec    = ecc_decode(arr_code_b);
        rd_view = rdec.data;
        if (!idle && r_addr == rd_addr) rd_view = byte_overlay(rd_view, r_data, r_mask);
        if (bv && baddr == rd_addr)     rd_view = byte_overlay(rd_view, bdata, bmask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ack           <= 1'b0;
            rd_data          <= '0;
            rd_corrected     <= 1'b0;
            rd_uncorrectable <= 1'b0;
        end else begin
            rd_ack <= rd_en;
            if (rd_en) begin
                rd_data          <= rd_view;
                rd_corrected     <= rdec.sgl;
                rd_uncorrectable <= rdec.dbl;
            end
        end
    end

    // R1: every freshly encoded codeword decodes clean
    p_encode_clean_r1: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> (!wchk.sgl && !wchk.dbl));
    // R4: a full-mask commit never enters the read sequence
    p_full_no_read_r4: assert property (@(posedge clk) disable iff (rst)
        commit_full |=> state_q == S_IDLE);
    // R5: a partial commit enters the read sequence
    p_partial_reads_r5: assert property (@(posedge clk) disable iff (rst)
        commit_part |=> (state_q == S_READ && !st_ready));
    // R5: the sequence lasts exactly two cycles
    p_rmw_len_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_MERGE) |=> st_ready);
    // R8: a double error blocks the write and pulses abort once
    p_abort_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        ((state_q == S_MERGE) && mdec.dbl) |-> (!arr_we ##1 rmw_abort));
    p_abort_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        rmw_abort |=> !rmw_abort);
    // R7: read answers one cycle later
    p_read_ack_r7: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_ack);
endmodule

// File: tb/tb_ecc_rmw_store.sv
module tb_ecc_rmw_store;
    import ecc_pkg::*;
    localparam int DEPTH = 16;
    localparam int AW = $clog2(DEPTH);

    logic clk = 1'b0, rst = 1'b1;
    logic st_valid = 0, flush = 0, rd_en = 0;
    logic st_ready, rd_ack, rd_corrected, rd_uncorrectable, rmw_abort;
    logic [AW-1:0] st_addr = '0, rd_addr = '0;
    logic [NBYTE-1:0] st_be = '0;
    logic [DW-1:0] st_data = '0, rd_data;
    logic [CW-1:0] inj_flip = '0;

    always #2 clk = ~clk;

    ecc_rmw_store #(.DEPTH(DEPTH)) dut (.*);

    typedef struct {
        logic [DW-1:0] d;
        bit            c;
        bit            u;
        bit            cd;
        string         tag;
    } exp_t;

    exp_t sbq[$];
    logic [DW-1:0] mdl [DEPTH];
    int flg [DEPTH];
    int n_chk = 0, n_err = 0, n_abort = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pop and compare read results
    always @(negedge clk) begin
        if (!rst && rd_ack) begin
            exp_t e;
            if (sbq.size() == 0) chk(0, "R7", "unexpected rd_ack", 1, 0);
            else begin
                e = sbq.pop_front();
                if (e.cd) chk(rd_data == e.d, e.tag, "rd_data", rd_data, e.d);
                chk(rd_corrected == e.c, e.tag, "rd_corrected", rd_corrected, e.c);
                chk(rd_uncorrectable == e.u, e.tag, "rd_uncorrectable", rd_uncorrectable, e.u);
            end
        end
        if (!rst && rmw_abort) n_abort++;
    end

    task automatic store(input int a, input logic [3:0] be, input logic [31:0] d);
        for (int i = 0; i < 4; i++) if (be[i]) mdl[a][i*8 +: 8] = d[i*8 +: 8];
        st_valid = 1; st_addr = AW'(a); st_be = be; st_data = d;
        while (!st_ready) @(negedge clk);
        @(negedge clk);
        st_valid = 0;
    endtask

    task automatic store_inj(input int a, input logic [31:0] d, input logic [CW-1:0] f);
        inj_flip = f;
        store(a, 4'hF, d);
        @(negedge clk);
        inj_flip = '0;
        flg[a] = $countones(f);
    endtask

    task automatic pulse_flush();
        flush = 1;
        @(negedge clk);
        flush = 0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic read_chk(input int a, input string tag, input bit cd);
        exp_t e;
        e.d = mdl[a]; e.c = (flg[a] == 1); e.u = (flg[a] == 2); e.cd = cd; e.tag = tag;
        sbq.push_back(e);
        rd_en = 1; rd_addr = AW'(a);
        @(negedge clk);
        rd_en = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin mdl[i] = '0; flg[i] = 0; end
        repeat (3) @(negedge clk);
        chk(st_ready == 1, "R10", "st_ready in reset", st_ready, 1);
        chk(rd_ack == 0, "R10", "rd_ack in reset", rd_ack, 0);
        rst = 0;
        @(negedge clk);
        chk(rmw_abort == 0, "R10", "rmw_abort after reset", rmw_abort, 0);
        read_chk(2, "R1 zero word after reset", 1);

        // R4: full word store goes direct
        store(3, 4'hF, 32'h11223344);
        @(negedge clk);
        chk(st_ready == 1, "R4", "st_ready after full commit", st_ready, 1);
        settle();
        read_chk(3, "R4 R1 full store", 1);

        // R4 R6: narrow stores filling a word skip the read
        store(7, 4'b0001, 32'h000000A0);
        store(7, 4'b0010, 32'h0000B100);
        store(7, 4'b0100, 32'h00C20000);
        store(7, 4'b1000, 32'hD3000000);
        chk(st_ready == 1, "R4", "st_ready merge-full 1", st_ready, 1);
        @(negedge clk);
        chk(st_ready == 1, "R4", "st_ready merge-full 2", st_ready, 1);
        settle();
        read_chk(7, "R6 R4 merged word", 1);

        // R5 R6: partial commit on different-word store
        store(3, 4'b0001, 32'h000000EE);
        store(5, 4'b0011, 32'h0000BEEF);
        chk(st_ready == 0, "R5", "stall cycle 1", st_ready, 0);
        @(negedge clk);
        chk(st_ready == 0, "R5", "stall cycle 2", st_ready, 0);
        @(negedge clk);
        chk(st_ready == 1, "R5", "ready after rmw", st_ready, 1);
        pulse_flush();
        settle();
        read_chk(3, "R5 merged old word", 1);
        read_chk(5, "R6 flush commit", 1);

        // R7: read served from buffer
        store(13, 4'b0100, 32'h00AB0000);
        read_chk(13, "R7 buffered bytes", 1);
        pulse_flush();
        settle();
        read_chk(13, "R7 after flush", 1);

        // R2 R9: single flips
        store_inj(9, 32'hCAFEF00D, 39'd1 << 10);
        settle();
        read_chk(9, "R2 R9 single data-position flip", 1);
        store_inj(12, 32'h0BADBEEF, 39'd1);
        settle();
        read_chk(12, "R2 overall parity flip", 1);
        store_inj(14, 32'h76543210, 39'd1 << 16);
        settle();
        read_chk(14, "R2 check-bit flip", 1);

        // R5: rmw corrects a single error
        store_inj(11, 32'h55667788, 39'd1 << 20);
        settle();
        read_chk(11, "R2 before rmw", 1);
        store(11, 4'b0010, 32'h00009900);
        pulse_flush();
        settle();
        flg[11] = 0;
        read_chk(11, "R5 corrected rewrite", 1);

        // R3 R8: double error aborts rmw
        store_inj(10, 32'h12345678, (39'd1 << 5) | (39'd1 << 30));
        settle();
        read_chk(10, "R3 double flip", 0);
        n_abort = 0;
        store(10, 4'b0001, 32'h000000FF);
        pulse_flush();
        settle();
        chk(n_abort == 1, "R8", "rmw_abort pulses", 64'(n_abort), 1);
        read_chk(10, "R8 word unchanged", 0);

        settle();
        chk(sbq.size() == 0, "R7", "reads answered", 64'(sbq.size()), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule